// File: doc/BRIEF.md
# Weighted-Count Circular Input Buffer

This block is a ring of 16-bit words placed between a host processor and a curve-processing engine. The host writes outline data words into the ring one at a time. It does not announce each word. Instead, once a whole record is in the ring, it reports that record with a two-bit size code. The consumer pulls words one per request, in the order they were written.

The buffer keeps an occupancy count that only record codes raise and only consumer reads lower. From that count it derives three status flags: empty, half-full and full. It also keeps a sticky error bit that flags an over-report past capacity. Write and read positions each wrap around the ring. Parsing the records is the consumer's task and lies outside this block.

Top module: `wcount_ring_buf`

## Requirements
- R1: After reset, empty is 1, half_full, full and ovf_err are 0, and rd_data is 0.
- R2: The count is raised by the code on rec_code: 2'b00 adds 0, 2'b01 adds 1 (end-of-character word), 2'b10 adds 2 (line record) and 2'b11 adds 4 (curve record). A word write with code 2'b00 leaves the count unchanged.
- R3: A read request accepted while the count is nonzero puts the oldest unread word on rd_data at the next rising clock edge. Words come out in the order they were written.
- R4: Each accepted read lowers the count by 1. When a read and a nonzero code arrive in the same cycle, both take effect.
- R5: empty is 1 exactly when the count is 0.
- R6: half_full is 1 exactly when the count is at least DEPTH/2 (256 by default).
- R7: full is 1 exactly when the count equals DEPTH (512 by default).
- R8: The write and read positions wrap modulo DEPTH, so data order holds across the end of the ring.
- R9: A code that would take the count above DEPTH sets ovf_err, and the count stays at DEPTH. ovf_err stays set until reset.
- R10: A read request while empty leaves rd_data holding its previous value and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Store wr_data at the write position and advance it |
| wr_data | input | 16 | Word from the host |
| rec_code | input | 2 | Record size code that raises the count |
| rd_req | input | 1 | Consumer request for the next word |
| rd_data | output | 16 | Last word handed to the consumer |
| empty | output | 1 | Count is zero |
| half_full | output | 1 | Count is at least half of capacity |
| full | output | 1 | Count equals capacity |
| ovf_err | output | 1 | Sticky: count was asked to exceed capacity |

## Verification
A wrong count inside the block shows at the flags only at a threshold: empty, half_full or full flips one or more cycles earlier or later than a running tally of codes and reads predicts. The checks therefore step the count across 0, 256 and 512 one cycle at a time. A read pointer that slips shows on rd_data at the very next edge as a word out of order. A miscounted read while empty remains hidden until the next drain, where empty rises at the wrong step. A lost sticky error shows at any later sample of ovf_err.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  typedef enum logic [1:0] {
    REC_NONE  = 2'b00,
    REC_END   = 2'b01,
    REC_LINE  = 2'b10,
    REC_CURVE = 2'b11
  } rec_code_e;

  localparam int WEIGHT_W = 3;

  // Amount one record code adds to the occupancy count
  function automatic logic [WEIGHT_W-1:0] rec_weight(input logic [1:0] code);
    case (rec_code_e'(code))
      REC_END:   return 3'd1;
      REC_LINE:  return 3'd2;
      REC_CURVE: return 3'd4;
      default:   return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/wcb_ptr.sv
module wcb_ptr #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);

  // Natural binary wrap gives modulo 2**ADDR_W
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= ptr + ADDR_W'(1);
  end

  // R8: a pointer only moves when told to
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/wcb_store.sv
module wcb_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // R10: output word holds whenever no read is accepted
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/wcb_occupancy.sv
module wcb_occupancy
  import wcb_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rec_code,
  input  logic             rd_req,
  output logic             rd_fire,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             half_full,
  output logic             full,
  output logic             ovf_err
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] CAP_S  = SUM_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(DEPTH / 2);

  // Unclamped next count, one bit wider than the count itself
  function automatic logic [SUM_W-1:0] raw_next(input logic [CNT_W-1:0] c,
                                                input logic [WEIGHT_W-1:0] w,
                                                input logic d);
    return SUM_W'(c) + SUM_W'(w) - SUM_W'(d);
  endfunction

  logic [WEIGHT_W-1:0] weight;
  logic [SUM_W-1:0]    sum;
  logic                over_cap;

  assign weight   = rec_weight(rec_code);
  assign rd_fire  = rd_req && (count != '0);
  assign sum      = raw_next(count, weight, rd_fire);
  assign over_cap = sum > CAP_S;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      ovf_err <= 1'b0;
    end else begin
      count <= over_cap ? CAP_C : sum[CNT_W-1:0];
      if (over_cap) ovf_err <= 1'b1;
    end
  end

  assign empty     = (count == '0);
  assign half_full = (count >= HALF_C);
  assign full      = (count == CAP_C);

  // R9: count never exceeds capacity
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP_C);

  // R9: error bit is sticky
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R6/R7: full implies half full
  assert_full_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> half_full);

  // R10: a read while empty with no code leaves the buffer empty
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && weight == '0) |=> empty);

  // R4: one read plus a weight-one code leaves the count where it was
  assert_both_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && weight == 3'd1) |=> $stable(count));

endmodule

// File: rtl/wcount_ring_buf.sv
module wcount_ring_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rec_code,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              half_full,
  output logic              full,
  output logic              ovf_err
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;

  logic              rd_fire;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;

  wcb_ptr #(.ADDR_W(ADDR_W)) i_wr_ptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_en), .ptr(wr_ptr)
  );

  wcb_ptr #(.ADDR_W(ADDR_W)) i_rd_ptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_fire), .ptr(rd_ptr)
  );

  wcb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .waddr(wr_ptr), .wdata(wr_data),
    .re(rd_fire), .raddr(rd_ptr), .rdata(rd_data)
  );

  wcb_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_occ (
    .clk(clk), .rst_n(rst_n),
    .rec_code(rec_code), .rd_req(rd_req),
    .rd_fire(rd_fire), .count(count),
    .empty(empty), .half_full(half_full), .full(full), .ovf_err(ovf_err)
  );

  // R9: the error can only appear after a nonzero record code
  assert_ovf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(rec_code) != 2'b00);

  // R10: requesting while empty leaves the output word untouched
  assert_empty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> $stable(rd_data));

  // R3: the read position moves only on an accepted read
  assert_rd_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> $past(rd_req) && !$past(empty));

endmodule

// File: tb/test_wcount_ring_buf.sv
`timescale 1ns/1ps
module test_wcount_ring_buf;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rec_code = 2'b00;
  logic        rd_req = 1'b0;
  logic [15:0] rd_data;
  logic        empty, half_full, full, ovf_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wcount_ring_buf i_wcount_ring_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rec_code(rec_code), .rd_req(rd_req), .rd_data(rd_data),
    .empty(empty), .half_full(half_full), .full(full), .ovf_err(ovf_err)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] wd;
    logic [1:0]  code;
    logic        rd;
    logic        exp_empty;
    logic [15:0] exp_rd;
  } vec_t;

  // Stimulus and results after the edge that samples it
  localparam vec_t VECS [15] = '{
    '{1'b1, 16'hA001, 2'b00, 1'b0, 1'b1, 16'h0000},
    '{1'b1, 16'hA002, 2'b00, 1'b0, 1'b1, 16'h0000},
    '{1'b1, 16'hA003, 2'b00, 1'b0, 1'b1, 16'h0000},
    '{1'b1, 16'hA004, 2'b11, 1'b0, 1'b0, 16'h0000},
    '{1'b0, 16'h0000, 2'b00, 1'b1, 1'b0, 16'hA001},
    '{1'b0, 16'h0000, 2'b00, 1'b1, 1'b0, 16'hA002},
    '{1'b1, 16'hB001, 2'b01, 1'b1, 1'b0, 16'hA003},
    '{1'b0, 16'h0000, 2'b00, 1'b1, 1'b0, 16'hA004},
    '{1'b0, 16'h0000, 2'b00, 1'b1, 1'b1, 16'hB001},
    '{1'b0, 16'h0000, 2'b00, 1'b1, 1'b1, 16'hB001},
    '{1'b1, 16'hC001, 2'b00, 1'b0, 1'b1, 16'hB001},
    '{1'b1, 16'hC002, 2'b10, 1'b0, 1'b0, 16'hB001},
    '{1'b0, 16'h0000, 2'b00, 1'b1, 1'b0, 16'hC001},
    '{1'b0, 16'h0000, 2'b00, 1'b1, 1'b1, 16'hC002},
    '{1'b0, 16'h0000, 2'b00, 1'b1, 1'b1, 16'hC002}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic step(input logic w, input logic [15:0] d,
                      input logic [1:0] c, input logic r);
    wr_en = w; wr_data = d; rec_code = c; rd_req = r;
    @(negedge clk);
    wr_en = 1'b0; rec_code = 2'b00; rd_req = 1'b0;
  endtask

  task automatic check_reset_state();
    chk("R1 empty", 16'(empty), 16'd1);
    chk("R1 half_full", 16'(half_full), 16'd0);
    chk("R1 full", 16'(full), 16'd0);
    chk("R1 ovf_err", 16'(ovf_err), 16'd0);
    chk("R1 rd_data", rd_data, 16'h0000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // R2 R3 R4 R5 R10: table of short records and reads
    for (int k = 0; k < 15; k++) begin
      step(VECS[k].wr, VECS[k].wd, VECS[k].code, VECS[k].rd);
      chk($sformatf("R2/R5 empty v%0d", k), 16'(empty), 16'(VECS[k].exp_empty));
      chk($sformatf("R3/R10 rd_data v%0d", k), rd_data, VECS[k].exp_rd);
    end

    // R6 R7 R8: fill to capacity with curve codes, wrapping the write side
    for (int i = 0; i < 512; i++) begin
      step(1'b1, 16'h1000 + 16'(i), (i % 4 == 3) ? 2'b11 : 2'b00, 1'b0);
      if (i == 251) chk("R6 half_full at 252", 16'(half_full), 16'd0);
      if (i == 255) chk("R6 half_full at 256", 16'(half_full), 16'd1);
      if (i == 507) chk("R7 full at 508", 16'(full), 16'd0);
      if (i == 511) chk("R7 full at 512", 16'(full), 16'd1);
    end

    // R9: over-report past capacity
    step(1'b0, 16'h0, 2'b01, 1'b0);
    chk("R9 ovf_err set", 16'(ovf_err), 16'd1);
    chk("R9 full kept", 16'(full), 16'd1);
    step(1'b0, 16'h0, 2'b00, 1'b1);
    chk("R9 saturated count after one read", 16'(full), 16'd0);
    chk("R8 first word after wrap", rd_data, 16'h1000);

    // R3 R8: drain in order across the ring end
    for (int i = 1; i < 512; i++) begin
      step(1'b0, 16'h0, 2'b00, 1'b1);
      chk($sformatf("R8 drain word %0d", i), rd_data, 16'h1000 + 16'(i));
      if (i == 510) chk("R5 not empty at 1", 16'(empty), 16'd0);
    end
    chk("R5 empty after drain", 16'(empty), 16'd1);
    chk("R9 ovf_err sticky", 16'(ovf_err), 16'd1);

    // R4: read and weight-one code together at the half threshold
    for (int i = 0; i < 256; i++)
      step(1'b1, 16'h2000 + 16'(i), (i % 4 == 3) ? 2'b11 : 2'b00, 1'b0);
    chk("R6 half_full at 256 again", 16'(half_full), 16'd1);
    step(1'b1, 16'h2100, 2'b01, 1'b1);
    chk("R4 read with code keeps 256", 16'(half_full), 16'd1);
    chk("R4 read data", rd_data, 16'h2000);
    step(1'b0, 16'h0, 2'b00, 1'b1);
    chk("R4 plain read drops to 255", 16'(half_full), 16'd0);
    chk("R3 next word", rd_data, 16'h2001);

    // R1 R9: reset clears everything including the error
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    finish_run();
  end

endmodule